// File: doc/BRIEF.md
# Register-Mapped Parallel I/O Port Block

This block places a set of 8-bit bidirectional pin groups into the upper, special-function part of a 12-bit data register space. For each group it keeps an output latch and a direction byte, and it returns the current pin levels when the group's data address is read. A write to a data address always loads the latch. The latched level reaches a pin only while that pin's direction bit selects output.

The first two groups share their low pins with analog input channels. One configuration byte decides how many of those channels remain analog. After reset every shared pin is analog and reads as zero. When the low nibble of the configuration byte is written with all ones, every shared pin becomes a plain digital pin. Pin levels cross into the clock domain through two flip-flops before a read can see them. Read data is registered and appears one cycle after the read strobe.

Top module: `sfr_gpio_port`

## Requirements
- R1: After reset every direction bit is 1, so `pin_oe` is all zeros. Every output latch is 0, so `pin_out` is all zeros. The configuration byte is 0x00.
- R2: Group i (A=0, B=1, C=2) maps its pin data to 0xF80+i, its latch readback to 0xF89+i and its direction byte to 0xF92+i, so group C direction is at 0xF94. The configuration byte is at 0xFC1. Reads of the direction, latch and configuration addresses return the stored byte.
- R3: Direction bit n of a group controls pin n of that group. A 1 makes the pin an input (`pin_oe` bit 0) and a 0 makes it an output (`pin_oe` bit 1). `pin_oe` and `pin_out` carry group i on bits [8i+7:8i].
- R4: A write to a data address loads the latch whatever the direction. A `pin_out` bit equals its latch bit while the pin is an output and is 0 while the pin is an input.
- R5: A read of a data address returns the pin levels after a two-flop synchronizer. A read strobed on the first or second rising edge after a pin change returns the old level. A read strobed on the third edge returns the new level. `bus_rdata` changes only on the edge that samples `bus_rd`.
- R6: Analog channels 0..4 are group A bits 0..4 and channels 5..9 are group B bits 0..4. While a channel is analog, its bit reads as 0 on a data read.
- R7: With v the low nibble of the configuration byte, channel j is analog when j+v < 15. With v = 15 all shared pins are digital, and with v <= 5 all are analog. Bits 7:4 of the configuration byte are stored but have no effect.
- R8: Analog mode affects only read data. It does not change `pin_oe` or `pin_out`, and bits 5..7 of groups A and B and all of group C always read as digital.
- R9: A read of an unmapped address returns 0x00. A write to an unmapped address changes no latch, direction or configuration state.
- R10: After group C's direction is written 0x00 and its data is written 0x55, `pin_out` for group C is 0x55, so alternate pins drive high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register-file address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data, valid the cycle after `bus_rd` |
| pin_in | input | 24 | Pin levels from the pads, group i on [8i+7:8i] |
| pin_out | output | 24 | Pad output values |
| pin_oe | output | 24 | Pad output enables, 1 = drive |

## Verification
The bench reads a group on the first, second and third edges after its pins change. A design with one synchronizer stage, or none, returns the new level too early. It then sweeps the configuration nibble through values that split the analog channels part way through group A and part way into group B. A threshold that is off by one, or a channel order that is reversed, shows up as wrong zero bits in the read bytes. It loads latches while the pins are inputs and checks that nothing drives until the direction changes, which catches a design that gates the write instead of the output. It also writes to addresses next to the mapped ones, which exposes a decoder that aliases them.

// File: rtl/sfr_gpio_port.sv
module sfr_gpio_port #(
  parameter int N_PORTS = 3,
  parameter int ADDR_W  = 12,
  parameter int ANA_A   = 5,
  parameter int ANA_B   = 5,
  parameter logic [ADDR_W-1:0] DATA_BASE = 12'hF80,
  parameter logic [ADDR_W-1:0] LAT_BASE  = 12'hF89,
  parameter logic [ADDR_W-1:0] DIR_BASE  = 12'hF92,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 12'hFC1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_wdata,
  input  logic                 bus_rd,
  output logic [7:0]           bus_rdata,
  input  logic [N_PORTS*8-1:0] pin_in,
  output logic [N_PORTS*8-1:0] pin_out,
  output logic [N_PORTS*8-1:0] pin_oe
);
  localparam int NW = N_PORTS * 8;

  logic [N_PORTS-1:0][7:0] lat_q, dir_q, ana;
  logic [NW-1:0]           sync1, sync2;
  logic [7:0]              cfg_q, rd_mux;
  logic                    mapped;
  logic [1:0]              age;

  assign pin_oe  = ~dir_q;
  assign pin_out = lat_q & ~dir_q;

  always_comb begin
    ana = '0;
    for (int j = 0; j < ANA_A; j++)
      if (j + int'(cfg_q[3:0]) < 15) ana[0][j] = 1'b1;
    for (int j = 0; j < ANA_B; j++)
      if (ANA_A + j + int'(cfg_q[3:0]) < 15) ana[1][j] = 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    mapped = (bus_addr == CFG_ADDR);
    if (bus_addr == CFG_ADDR) rd_mux = cfg_q;
    for (int i = 0; i < N_PORTS; i++) begin
      if (bus_addr == DATA_BASE + ADDR_W'(i)) begin
        rd_mux = sync2[i*8 +: 8] & ~ana[i];
        mapped = 1'b1;
      end
      if (bus_addr == LAT_BASE + ADDR_W'(i)) begin
        rd_mux = lat_q[i];
        mapped = 1'b1;
      end
      if (bus_addr == DIR_BASE + ADDR_W'(i)) begin
        rd_mux = dir_q[i];
        mapped = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q     <= '0;
      dir_q     <= '1;
      cfg_q     <= '0;
      sync1     <= '0;
      sync2     <= '0;
      bus_rdata <= '0;
      age       <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      if (age != 2'd3) age <= age + 2'd1;
      if (bus_wr) begin
        if (bus_addr == CFG_ADDR) cfg_q <= bus_wdata;
        for (int i = 0; i < N_PORTS; i++) begin
          if (bus_addr == DATA_BASE + ADDR_W'(i)) lat_q[i] <= bus_wdata;
          if (bus_addr == DIR_BASE + ADDR_W'(i)) dir_q[i] <= bus_wdata;
        end
      end
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  for (genvar g = 0; g < N_PORTS; g++) begin : g_chk
    // R3
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == DIR_BASE + ADDR_W'(g))
      |=> pin_oe[g*8 +: 8] == ~$past(bus_wdata));
    // R4
    lat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == DATA_BASE + ADDR_W'(g))
      |=> pin_out[g*8 +: 8] == ($past(bus_wdata) & pin_oe[g*8 +: 8]));
    if (g >= 2) begin : g_sync
      // R5
      sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == DATA_BASE + ADDR_W'(g) && age == 2'd3)
        |=> bus_rdata == $past(pin_in[g*8 +: 8], 3));
    end
  end

  // R6
  analog_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == DATA_BASE && cfg_q[3:0] != 4'hF)
    |=> bus_rdata[0] == 1'b0);

  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !mapped) |=> bus_rdata == 8'h00);

  // R5
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/sfr_gpio_port_tb.sv
module sfr_gpio_port_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [23:0] pin_in = 24'h00FFFF;
  logic [23:0] pin_out, pin_oe;

  int n_vec = 0, n_bad = 0;
  logic rd_seen = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  sfr_gpio_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if (bus_rdata !== e) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [7:0] e, input string t);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk(input logic [23:0] act, input logic [23:0] e, input string t);
    n_vec++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", t, act, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    chk(pin_oe, 24'h0, "R1 oe in reset");
    rst_n = 1'b1;
    chk(pin_out, 24'h0, "R1 out after reset");
    idle(3);
    rd(12'hF94, 8'hFF, "R1 R2 dir C reset");
    rd(12'hF92, 8'hFF, "R2 dir A reset");
    rd(12'hFC1, 8'h00, "R1 cfg reset");
    rd(12'hF89, 8'h00, "R1 latch A reset");
    rd(12'hF80, 8'hE0, "R6 group A analog reads zero");
    rd(12'hF81, 8'hE0, "R6 group B analog reads zero");

    wr(12'hF82, 8'h3C);
    chk(pin_out[23:16], 8'h00, "R4 latch hidden while input");
    rd(12'hF8B, 8'h3C, "R4 latch loaded while input");
    wr(12'hF94, 8'h00);
    chk(pin_oe[23:16], 8'hFF, "R3 all outputs");
    chk(pin_out[23:16], 8'h3C, "R4 latch appears");
    wr(12'hF82, 8'h55);
    chk(pin_out[23:16], 8'h55, "R10 alternate pins high");
    wr(12'hF94, 8'hF0);
    chk(pin_oe[23:16], 8'h0F, "R3 per-bit direction");
    chk(pin_out[23:16], 8'h05, "R4 input bits forced low");

    wr(12'hF92, 8'hF0);
    wr(12'hF80, 8'h0F);
    chk(pin_oe[7:0], 8'h0F, "R8 analog does not touch oe");
    chk(pin_out[7:0], 8'h0F, "R8 analog does not touch out");

    pin_in[23:16] = 8'hA5;
    rd(12'hF82, 8'h00, "R5 edge 1 old level");
    rd(12'hF82, 8'h00, "R5 edge 2 old level");
    rd(12'hF82, 8'hA5, "R5 edge 3 new level");

    wr(12'hFC1, 8'h0D);
    rd(12'hF80, 8'hFC, "R7 v=13 channels 0,1 analog");
    rd(12'hF81, 8'hFF, "R7 v=13 group B digital");
    wr(12'hFC1, 8'h08);
    rd(12'hF80, 8'hE0, "R7 v=8 group A analog");
    rd(12'hF81, 8'hFC, "R7 v=8 channels 5,6 analog");
    wr(12'hFC1, 8'h0F);
    rd(12'hF80, 8'hFF, "R7 v=15 group A digital");
    rd(12'hF81, 8'hFF, "R7 v=15 group B digital");
    rd(12'hFC1, 8'h0F, "R2 cfg readback");
    wr(12'hFC1, 8'hF5);
    rd(12'hF80, 8'hE0, "R7 upper nibble ignored");
    rd(12'hFC1, 8'hF5, "R7 upper nibble stored");

    rd(12'hF95, 8'h00, "R9 unmapped read");
    wr(12'hF83, 8'hFF);
    wr(12'hF95, 8'h00);
    wr(12'hF8C, 8'hAA);
    chk(pin_oe, 24'h0F000F, "R9 unmapped write oe");
    chk(pin_out, 24'h05000F, "R9 unmapped write out");
    rd(12'hF93, 8'hFF, "R9 dir B unchanged");
    rd(12'hFC1, 8'hF5, "R9 cfg unchanged");

    idle(3);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule